// File: doc/BRIEF.md
# Two-Wire Target Byte Bridge

This block sits on the target side of a two-wire serial bus. It watches the clock line and the data line that an external bus controller drives. It turns the bit-level activity into single-cycle byte strobes on a simple internal port. That port carries a transaction start with a 7-bit address and a direction flag, a write byte, a read-byte fetch, a notice when the controller refuses read data, and an end-of-transfer marker.

The bridge has no address of its own. Every addressed transaction is forwarded, and the downstream side decides in the same system-clock cycle whether to accept it. The bridge drives its own data output, which is wired-AND with the controller's line. The level it reports back is its own drive combined with the controller's level. It acknowledges accepted bytes, shifts out read bytes, and gives up the transfer when the downstream side refuses.

Both bus lines pass through a synchroniser into the system clock domain. Edges are detected against the previous synchronised sample. If both lines change in the same cycle, the change counts as a clock edge, and the new data level is used as the bit value.

Top module: `i2c_byte_bridge`

## Requirements
- R1: After reset `sda_o` is 1, no downstream strobe fires, and bits clocked without a preceding START produce no strobe and no acknowledge.
- R2: A data fall while the clock is high (START) begins a new transaction whose first byte is taken as an address. A START inside a transaction (repeated START) does not pulse `dn_end`.
- R3: Data bits are sampled on clock rising edges, MSB first. Data changes while the clock is low never count as START or STOP.
- R4: In the acknowledge clock of the first byte, `dn_start` pulses once with `dn_addr` = byte[7:1] and `dn_rd` = byte[0]. In later bytes `dn_wr` pulses with `dn_wdata` equal to the byte.
- R5: When the downstream side accepts the byte, `sda_o` is 0 during the high phase of the acknowledge clock, and it returns to 1 after that clock falls.
- R6: When the downstream side refuses an address or a write, `sda_o` stays 1 in the acknowledge slot and `dn_end` pulses at once. Further clocks produce no strobe until the next START.
- R7: In read mode, `dn_rd_req` pulses on the first clock rise of each byte. The byte from `dn_rdata` then appears MSB first on `sda_o`, one bit per clock high phase, for eight clocks.
- R8: In the ninth clock of a read byte, a low level from the controller starts the next fetch. A high level pulses `dn_nack` once, and no further fetch occurs.
- R9: A data rise while the clock is high (STOP) pulses `dn_end` only if an address was captured since the last START. It then returns to idle.
- R10: `sda_o` is the bridge's own drive ANDed with the controller's data level, so a controller holding the line low reads 0 even while the bridge shifts out a 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock from the controller |
| sda_i | input | 1 | Bus data level from the controller |
| sda_o | output | 1 | Resolved data level: own drive AND controller level |
| dn_start | output | 1 | Transaction start strobe |
| dn_addr | output | 7 | Target address carried with `dn_start` |
| dn_rd | output | 1 | Read flag carried with `dn_start` |
| dn_start_ok | input | 1 | Downstream accepts the address, same cycle as `dn_start` |
| dn_wr | output | 1 | Write-byte strobe |
| dn_wdata | output | 8 | Write byte carried with `dn_wr` |
| dn_wr_ok | input | 1 | Downstream accepts the write byte, same cycle as `dn_wr` |
| dn_rd_req | output | 1 | Read-byte fetch strobe |
| dn_rdata | input | 8 | Read byte, valid in the same cycle as `dn_rd_req` |
| dn_nack | output | 1 | Controller refused further read data |
| dn_end | output | 1 | End-of-transfer strobe |

## Verification
The bench targets these corner cases:
- Data glitches while the clock is low. A design that took them for START or STOP would corrupt the write bytes or lose the address.
- Repeated START. A design that closed the transfer there would emit an extra `dn_end`.
- Refused addresses and refused writes. A design that skipped the stop sequence would keep acknowledging or strobing bytes afterwards.
- STOP without a captured address. A sloppy design would emit a stray `dn_end` here.
- Read slots where the controller holds data low. A design that reported only its own drive would show a 1 where the bus carries a 0.

Random write data, pointers and glitch placement are mixed with these directed cases.

// File: rtl/i2cbb_pkg.sv
package i2cbb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_SHIFT_IN  = 3'd1,
      ST_ACK_SLOT  = 3'd2,
      ST_SHIFT_OUT = 3'd3,
      ST_HOST_ACK  = 3'd4,
      ST_REFUSED   = 3'd5
   } bridge_state_t;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
      logic bit_val;
   } bus_evt_t;

endpackage

// File: rtl/i2cbb_sync.sv
module i2cbb_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cbb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2cbb_edge.sv
module i2cbb_edge
   import i2cbb_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt,
   output logic     sda_level
);

   logic scl_q;
   logic sda_q;
   logic scl_chg;
   logic sda_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_chg = scl_s ^ scl_q;
   assign sda_chg = sda_s ^ sda_q;

   // a clock edge wins over a data edge in the same cycle
   always_comb begin
      evt.scl_rise = scl_chg &  scl_s;
      evt.scl_fall = scl_chg & ~scl_s;
      evt.start    = ~scl_chg & scl_q & sda_chg & ~sda_s;
      evt.stop     = ~scl_chg & scl_q & sda_chg &  sda_s;
      evt.bit_val  = sda_s;
   end

   assign sda_level = sda_q;

   AST_LOW_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_q && !scl_s) |-> !(evt.start || evt.stop)); // R3

endmodule

// File: rtl/i2cbb_core.sv
module i2cbb_core
   import i2cbb_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int ADDR_W = DATA_W - 1,
   localparam int CNT_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt,
   output logic              own_drv,
   output logic              dn_start,
   output logic [ADDR_W-1:0] dn_addr,
   output logic              dn_rd,
   input  logic              dn_start_ok,
   output logic              dn_wr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_wr_ok,
   output logic              dn_rd_req,
   input  logic [DATA_W-1:0] dn_rdata,
   output logic              dn_nack,
   output logic              dn_end
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   bridge_state_t     st;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg;
   logic              have_addr;
   logic              rd_mode;

   logic              in_ack_rise;
   logic              accept;
   logic              refuse;
   logic              next_rd;
   logic [DATA_W-1:0] out_byte;
   logic              out_bit;

   // downstream request strobes
   assign in_ack_rise = evt.scl_rise && (st == ST_ACK_SLOT);
   assign dn_start    = in_ack_rise && !have_addr;
   assign dn_wr       = in_ack_rise &&  have_addr;
   assign dn_addr     = shreg[DATA_W-1:1];
   assign dn_rd       = shreg[0];
   assign dn_wdata    = shreg;
   assign dn_rd_req   = evt.scl_rise && (st == ST_SHIFT_OUT) && (cnt == '0);
   assign dn_nack     = evt.scl_rise && (st == ST_HOST_ACK) && evt.bit_val;

   assign accept  = (dn_start && dn_start_ok) || (dn_wr && dn_wr_ok);
   assign refuse  = (dn_start && !dn_start_ok) || (dn_wr && !dn_wr_ok);
   assign dn_end  = (evt.stop && have_addr) || refuse;
   assign next_rd = have_addr ? rd_mode : shreg[0];

   // read byte: fresh from downstream on the first bit, shifted copy after
   assign out_byte = (cnt == '0) ? dn_rdata : shreg;
   assign out_bit  = out_byte[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         shreg     <= '0;
         have_addr <= 1'b0;
         rd_mode   <= 1'b0;
         own_drv   <= 1'b1;
      end else if (evt.start) begin
         st        <= ST_SHIFT_IN;
         cnt       <= '0;
         have_addr <= 1'b0;
         own_drv   <= 1'b1;
      end else if (evt.stop) begin
         st        <= ST_IDLE;
         have_addr <= 1'b0;
         own_drv   <= 1'b1;
      end else if (evt.scl_fall) begin
         own_drv <= 1'b1;
      end else if (evt.scl_rise) begin
         unique case (st)
            ST_SHIFT_IN: begin
               shreg   <= {shreg[DATA_W-2:0], evt.bit_val};
               cnt     <= cnt + CNT_W'(1);
               own_drv <= 1'b1;
               if (cnt == LAST_BIT) st <= ST_ACK_SLOT;
            end
            ST_ACK_SLOT: begin
               if (accept) begin
                  own_drv   <= 1'b0;
                  have_addr <= 1'b1;
                  if (!have_addr) rd_mode <= shreg[0];
                  st        <= next_rd ? ST_SHIFT_OUT : ST_SHIFT_IN;
                  cnt       <= '0;
               end else begin
                  own_drv   <= 1'b1;
                  have_addr <= 1'b0;
                  st        <= ST_IDLE;
               end
            end
            ST_SHIFT_OUT: begin
               own_drv <= out_bit;
               shreg   <= {out_byte[DATA_W-2:0], 1'b0};
               cnt     <= cnt + CNT_W'(1);
               if (cnt == LAST_BIT) st <= ST_HOST_ACK;
            end
            ST_HOST_ACK: begin
               own_drv <= 1'b1;
               if (evt.bit_val) begin
                  st <= ST_REFUSED;
               end else begin
                  st  <= ST_SHIFT_OUT;
                  cnt <= '0;
               end
            end
            default: own_drv <= 1'b1;
         endcase
      end
   end

   AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.scl_fall && !evt.start && !evt.stop) |=> own_drv); // R5
   AST_ACK_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !own_drv); // R5
   AST_REFUSE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> (own_drv && st == ST_IDLE)); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_REFUSED) |-> !(dn_start || dn_wr || dn_rd_req || dn_nack)); // R6
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      dn_start |=> !dn_start); // R4
   AST_FETCH_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      dn_rd_req |=> (cnt == CNT_W'(1) && st == ST_SHIFT_OUT)); // R7
   AST_NACK_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      dn_nack |=> (st == ST_REFUSED)); // R8
   AST_END_CLEARS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      dn_end |=> !have_addr); // R9

endmodule

// File: rtl/i2c_byte_bridge.sv
module i2c_byte_bridge
   import i2cbb_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0,
   localparam int ADDR_W     = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_o,
   output logic              dn_start,
   output logic [ADDR_W-1:0] dn_addr,
   output logic              dn_rd,
   input  logic              dn_start_ok,
   output logic              dn_wr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_wr_ok,
   output logic              dn_rd_req,
   input  logic [DATA_W-1:0] dn_rdata,
   output logic              dn_nack,
   output logic              dn_end
);

   if (DATA_W < 2) begin : g_bad_width
      $error("i2c_byte_bridge: DATA_W must be at least 2");
   end

   logic     scl_s;
   logic     sda_s;
   bus_evt_t evt;
   logic     sda_level;
   logic     own_drv;
   logic     wired;

   i2cbb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   i2cbb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2cbb_edge u_edge (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .evt(evt), .sda_level(sda_level));

   i2cbb_core #(.DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .evt(evt), .own_drv(own_drv),
      .dn_start(dn_start), .dn_addr(dn_addr), .dn_rd(dn_rd),
      .dn_start_ok(dn_start_ok), .dn_wr(dn_wr), .dn_wdata(dn_wdata),
      .dn_wr_ok(dn_wr_ok), .dn_rd_req(dn_rd_req), .dn_rdata(dn_rdata),
      .dn_nack(dn_nack), .dn_end(dn_end));

   assign wired = own_drv & sda_level;

   if (OUT_REG) begin : g_out_flop
      logic sda_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sda_r <= 1'b1;
         else        sda_r <= wired;
      end
      assign sda_o = sda_r;
   end else begin : g_out_comb
      assign sda_o = wired;
   end

   AST_LOW_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sda_level && !OUT_REG) |-> !sda_o); // R10
   AST_END_NOT_WITH_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      dn_end |-> !(dn_rd_req || dn_nack)); // R9

endmodule

// File: tb/i2c_byte_bridge_tb.sv
module i2c_byte_bridge_tb;

   localparam logic [6:0] DEV = 7'h2A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda = 1'b1;
   logic sda_o;
   logic dn_start, dn_rd, dn_wr, dn_rd_req, dn_nack, dn_end;
   logic [6:0] dn_addr;
   logic [7:0] dn_wdata, dn_rdata;
   logic dn_start_ok, dn_wr_ok;
   logic wr_refuse = 1'b0;

   int n_chk = 0, n_err = 0;
   int cnt_start = 0, cnt_wr = 0, cnt_rd = 0, cnt_nack = 0, cnt_end = 0;
   logic [6:0] last_addr = '0;
   logic last_rd = 1'b0;
   logic [7:0] last_wdata = '0;
   bit done = 1'b0;

   logic [7:0] mem [4];
   logic [7:0] exp_mem [4];
   logic [1:0] ptr;
   logic first_wr;

   always #10 clk = ~clk;

   i2c_byte_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_o(sda_o),
      .dn_start(dn_start), .dn_addr(dn_addr), .dn_rd(dn_rd),
      .dn_start_ok(dn_start_ok), .dn_wr(dn_wr), .dn_wdata(dn_wdata),
      .dn_wr_ok(dn_wr_ok), .dn_rd_req(dn_rd_req), .dn_rdata(dn_rdata),
      .dn_nack(dn_nack), .dn_end(dn_end));

   // downstream model: one device, four byte registers, auto-increment pointer
   assign dn_start_ok = (dn_addr == DEV);
   assign dn_wr_ok    = !wr_refuse;
   assign dn_rdata    = mem[ptr];

   always @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         first_wr <= 1'b0;
      end else begin
         if (dn_start && dn_start_ok) first_wr <= !dn_rd;
         if (dn_wr && dn_wr_ok) begin
            if (first_wr) begin
               ptr <= dn_wdata[1:0];
               first_wr <= 1'b0;
            end else begin
               mem[ptr] <= dn_wdata;
               ptr <= ptr + 2'd1;
            end
         end
         if (dn_rd_req) ptr <= ptr + 2'd1;
      end
   end

   always @(negedge clk) begin
      if (dn_start) begin cnt_start++; last_addr = dn_addr; last_rd = dn_rd; end
      if (dn_wr) begin cnt_wr++; last_wdata = dn_wdata; end
      if (dn_rd_req) cnt_rd++;
      if (dn_nack) cnt_nack++;
      if (dn_end) cnt_end++;
   end

   function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
      return {a, rd};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      repeat (8) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_start();
      sda = 1'b1; step(); scl = 1'b1; step();
      sda = 1'b0; step(); scl = 1'b0; step();
   endtask

   task automatic bus_stop();
      sda = 1'b0; step(); scl = 1'b1; step(); sda = 1'b1; step();
   endtask

   task automatic clock_bit(input logic b);
      sda = b; step(); scl = 1'b1; step(); scl = 1'b0; step();
   endtask

   task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         if (glitch) begin sda = ~b[i]; step(); end
         clock_bit(b[i]);
      end
      sda = 1'b1; step(); scl = 1'b1; step();
      ack = sda_o;
      scl = 1'b0; step();
      chk(sda_o == 1'b1, "R5 release after ack clock", sda_o, 1);
   endtask

   task automatic recv_byte(input bit host_ack, input bit hold_first, output logic [7:0] b);
      b = '0;
      for (int i = 7; i >= 0; i--) begin
         sda = (hold_first && i == 7) ? 1'b0 : 1'b1;
         step(); scl = 1'b1; step();
         b[i] = sda_o;
         scl = 1'b0; step();
      end
      clock_bit(host_ack ? 1'b0 : 1'b1);
      sda = 1'b1; step();
   endtask

   task automatic write_txn(input logic [1:0] p, input int n, input bit glitch);
      logic ack;
      logic [7:0] d;
      int e0;
      bus_start();
      send_byte(addr_byte(DEV, 1'b0), glitch, ack);
      chk(ack == 1'b0, "R5 address ack low", ack, 0);
      chk(last_addr == DEV && last_rd == 1'b0, "R4 address fields", {last_addr, last_rd}, {DEV, 1'b0});
      send_byte({6'd0, p}, glitch, ack);
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         exp_mem[2'(p + k)] = d;
         send_byte(d, glitch, ack);
         chk(last_wdata == d && ack == 1'b0, glitch ? "R3 write byte with low-clock glitches" : "R4 write byte", last_wdata, d);
      end
      e0 = cnt_end;
      bus_stop();
      chk(cnt_end == e0 + 1, "R9 stop after address ends transfer", cnt_end, e0 + 1);
   endtask

   task automatic read_txn(input logic [1:0] p, input int n, input bit hold);
      logic ack;
      logic [7:0] b, e;
      int e0, r0, k0;
      bus_start();
      send_byte(addr_byte(DEV, 1'b0), 1'b0, ack);
      send_byte({6'd0, p}, 1'b0, ack);
      e0 = cnt_end;
      bus_start();
      chk(cnt_end == e0, "R2 repeated start gives no end", cnt_end, e0);
      send_byte(addr_byte(DEV, 1'b1), 1'b0, ack);
      chk(last_rd == 1'b1 && ack == 1'b0, "R2 address after repeated start", last_rd, 1);
      r0 = cnt_rd; k0 = cnt_nack;
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, hold && k == 0, b);
         e = exp_mem[2'(p + k)];
         if (hold && k == 0) begin
            e[7] = 1'b0;
            chk(b == e, "R10 controller low wins on read bit", b, e);
         end else begin
            chk(b == e, "R7 read byte MSB first", b, e);
         end
      end
      chk(cnt_rd == r0 + n, "R8 one fetch per acked byte", cnt_rd, r0 + n);
      chk(cnt_nack == k0 + 1, "R8 controller nack notice", cnt_nack, k0 + 1);
      e0 = cnt_end;
      bus_stop();
      chk(cnt_end == e0 + 1, "R9 stop ends read transfer", cnt_end, e0 + 1);
   endtask

   initial begin
      logic ack;
      int s0, w0, e0;
      void'($urandom(32'd4711));
      for (int i = 0; i < 4; i++) begin mem[i] = '0; exp_mem[i] = '0; end
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      step();
      chk(sda_o == 1'b1, "R1 reset level", sda_o, 1);
      chk(cnt_start + cnt_wr + cnt_rd + cnt_nack + cnt_end == 0, "R1 no strobes after reset", cnt_start, 0);

      send_byte(addr_byte(DEV, 1'b0), 1'b0, ack);
      chk(cnt_start == 0 && cnt_wr == 0, "R1 bits without start ignored", cnt_start, 0);
      chk(ack == 1'b1, "R1 no ack without start", ack, 1);

      write_txn(2'd0, 4, 1'b0);
      read_txn(2'd0, 4, 1'b0);
      write_txn(2'd1, 2, 1'b1);
      read_txn(2'd3, 3, 1'b1);

      // refused address
      s0 = cnt_start; w0 = cnt_wr; e0 = cnt_end;
      bus_start();
      send_byte(addr_byte(7'h11, 1'b0), 1'b0, ack);
      chk(ack == 1'b1, "R6 refused address not acked", ack, 1);
      chk(cnt_start == s0 + 1 && cnt_end == e0 + 1, "R6 refused address ends transfer", cnt_end, e0 + 1);
      send_byte(8'h5A, 1'b0, ack);
      chk(cnt_wr == w0 && ack == 1'b1, "R6 clocks ignored after refusal", cnt_wr, w0);
      bus_stop();
      chk(cnt_end == e0 + 1, "R9 stop without address gives no end", cnt_end, e0 + 1);

      // refused write
      wr_refuse = 1'b1;
      bus_start();
      send_byte(addr_byte(DEV, 1'b0), 1'b0, ack);
      e0 = cnt_end;
      send_byte(8'h02, 1'b0, ack);
      chk(ack == 1'b1 && cnt_end == e0 + 1, "R6 refused write", {ack, 8'(cnt_end)}, {1'b1, 8'(e0 + 1)});
      w0 = cnt_wr;
      send_byte(8'hC3, 1'b0, ack);
      chk(cnt_wr == w0, "R6 no write after refusal", cnt_wr, w0);
      bus_stop();
      wr_refuse = 1'b0;

      // start then stop with no byte
      e0 = cnt_end;
      bus_start();
      bus_stop();
      chk(cnt_end == e0, "R9 empty transaction gives no end", cnt_end, e0);

      // random mix
      for (int t = 0; t < 6; t++) begin
         write_txn(2'($urandom), 1 + int'($urandom % 3), 1'($urandom));
         read_txn(2'($urandom), 1 + int'($urandom % 4), 1'($urandom));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule